// File: doc/BRIEF.md
# Pipeline Run-State Controller

This block keeps track of the run state of a small pipelined processor and decides, cycle by cycle, whether a requested clock step may advance the pipeline and whether a new instruction may be fetched. The block is driven by five flags. The first is a program-load pulse. The second is a step request, which asks for one processor cycle. The third says that a termination instruction has been decoded. The fourth says that only the last in-flight instruction remains in the pipeline. The fifth says that an instruction leaves write-back on this step. The datapath reads the two enables that the block drives. The cycle counter and the retired-instruction counter are available to whatever observes the run.

The controller has four named states: IDLE_LOADED (a program is loaded and nothing has run), EXECUTING, DRAINING and STOPPED. The transitions are as follows:
- load, from any state to IDLE_LOADED;
- first step, from IDLE_LOADED to EXECUTING;
- terminate, from EXECUTING to DRAINING, on a step with the termination flag set;
- drain done, from DRAINING to STOPPED, on a step with the last-instruction flag set.

In DRAINING the instructions already in flight keep moving, but nothing new is fetched. The final drain step only retires the last instruction, so it is not counted as a cycle. A missing step request is a pause, and a pause never changes the state.

Top module: `cpu_runstate_ctrl`

## Requirements
- R1: After reset, the status is IDLE_LOADED, both counters are zero, and with no request pending `adv_en` and `fetch_en` are low.
- R2: The status output is encoded as IDLE_LOADED=2'b00, EXECUTING=2'b01, DRAINING=2'b10 and STOPPED=2'b11.
- R3: In the same cycle, `adv_en` equals `step_req` in every state except STOPPED, unless `load_pulse` is high. An advanced step in IDLE_LOADED moves the status to EXECUTING at the next edge.
- R4: Every advanced step except the final drain step adds one to `cycle_cnt`. A cycle without `step_req` changes neither the status nor either counter.
- R5: An advanced step with `retire_seen` high adds one to `retired_cnt`.
- R6: An advanced step in EXECUTING with `term_seen` high moves the status to DRAINING. `fetch_en` is low on that step.
- R7: In DRAINING, `fetch_en` stays low. An advanced step with `last_inflight` low keeps the status at DRAINING and is counted as a cycle.
- R8: An advanced step in DRAINING with `last_inflight` high is the final step. It moves the status to STOPPED and leaves `cycle_cnt` unchanged. It still adds to `retired_cnt` when `retire_seen` is high.
- R9: In STOPPED, step requests are ignored: `adv_en` and `fetch_en` stay low, and the status and counters stay frozen.
- R10: `load_pulse` in any state holds `adv_en` and `fetch_en` low in that cycle. At the next edge it sets the status to IDLE_LOADED and clears both counters.
- R11: In IDLE_LOADED and in EXECUTING without `term_seen`, `fetch_en` equals `adv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_pulse | input | 1 | A program has been loaded; return to IDLE_LOADED |
| step_req | input | 1 | Request for one processor cycle |
| term_seen | input | 1 | A termination instruction was decoded on this step |
| last_inflight | input | 1 | Only the last in-flight instruction remains |
| retire_seen | input | 1 | An instruction leaves write-back on this step |
| status | output | 2 | Run-state code |
| fetch_en | output | 1 | A new instruction may be fetched on this step |
| adv_en | output | 1 | The pipeline advances on this step |
| cycle_cnt | output | CNT_W | Number of counted cycles |
| retired_cnt | output | CNT_W | Number of retired instructions |

## Verification
`adv_en` and `fetch_en` are combinational, so they are due in the same cycle as the request. The bench drives each request at the falling edge and samples the two enables shortly after, well before the next rising edge. `status`, `cycle_cnt` and `retired_cnt` are registered and change at the first rising edge after the request. Each scenario task therefore reads them one time step after that edge, before the inputs change again.

// File: rtl/runstate_pkg.sv
package runstate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE_LOADED = 2'b00,
        ST_EXECUTING   = 2'b01,
        ST_DRAINING    = 2'b10,
        ST_STOPPED     = 2'b11
    } run_state_t;
endpackage

// File: rtl/runstate_fsm.sv
module runstate_fsm
    import runstate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_pulse,
    input  logic       step_req,
    input  logic       term_seen,
    input  logic       last_inflight,
    output run_state_t state,
    output logic       adv_en,
    output logic       fetch_en,
    output logic       final_step
);
    run_state_t nxt;

    // next state
    always_comb begin
        nxt = state;
        if (load_pulse) begin
            nxt = ST_IDLE_LOADED;
        end else if (step_req) begin
            unique case (state)
                ST_IDLE_LOADED: nxt = ST_EXECUTING;
                ST_EXECUTING:   nxt = term_seen ? ST_DRAINING : ST_EXECUTING;
                ST_DRAINING:    nxt = last_inflight ? ST_STOPPED : ST_DRAINING;
                ST_STOPPED:     nxt = ST_STOPPED;
                default:        nxt = ST_IDLE_LOADED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE_LOADED;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        adv_en     = 1'b0;
        fetch_en   = 1'b0;
        final_step = 1'b0;
        if (!load_pulse && step_req) begin
            unique case (state)
                ST_IDLE_LOADED: begin
                    adv_en   = 1'b1;
                    fetch_en = 1'b1;
                end
                ST_EXECUTING: begin
                    adv_en   = 1'b1;
                    fetch_en = !term_seen;
                end
                ST_DRAINING: begin
                    adv_en     = 1'b1;
                    final_step = last_inflight;
                end
                ST_STOPPED: adv_en = 1'b0;
                default:    adv_en = 1'b0;
            endcase
        end
    end

    assert_stopped_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED && !load_pulse) |=> (state == ST_STOPPED));
    assert_no_fetch_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAINING) |-> !fetch_en);
    assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (state == ST_IDLE_LOADED));
    assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_req && !load_pulse) |=> $stable(state));
endmodule

// File: rtl/runstate_counter.sv
module runstate_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (inc) value <= value + ONE;
    end

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(value));
endmodule

// File: rtl/cpu_runstate_ctrl.sv
module cpu_runstate_ctrl
    import runstate_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_pulse,
    input  logic             step_req,
    input  logic             term_seen,
    input  logic             last_inflight,
    input  logic             retire_seen,
    output logic [1:0]       status,
    output logic             fetch_en,
    output logic             adv_en,
    output logic [CNT_W-1:0] cycle_cnt,
    output logic [CNT_W-1:0] retired_cnt
);
    run_state_t st;
    logic       fin;
    logic       cyc_inc;
    logic       ret_inc;

    runstate_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_pulse    (load_pulse),
        .step_req      (step_req),
        .term_seen     (term_seen),
        .last_inflight (last_inflight),
        .state         (st),
        .adv_en        (adv_en),
        .fetch_en      (fetch_en),
        .final_step    (fin)
    );

    assign status  = st;
    assign cyc_inc = adv_en && !fin;
    assign ret_inc = adv_en && retire_seen;

    runstate_counter #(.W(CNT_W)) u_cycles (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_pulse),
        .inc   (cyc_inc),
        .value (cycle_cnt)
    );

    runstate_counter #(.W(CNT_W)) u_retired (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_pulse),
        .inc   (ret_inc),
        .value (retired_cnt)
    );

    assert_final_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && step_req && last_inflight && !load_pulse)
            |=> (status == 2'b11 && cycle_cnt == $past(cycle_cnt)));
    assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (cycle_cnt == '0 && retired_cnt == '0));
endmodule

// File: tb/cpu_runstate_ctrl_test.sv
module cpu_runstate_ctrl_test;
    localparam int CNT_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_pulse = 1'b0, step_req = 1'b0, term_seen = 1'b0;
    logic last_inflight = 1'b0, retire_seen = 1'b0;
    logic [1:0] status;
    logic fetch_en, adv_en;
    logic [CNT_W-1:0] cycle_cnt, retired_cnt;

    int n_chk = 0;
    int n_bad = 0;
    logic seen_adv, seen_fetch;

    always #2 clk = ~clk;

    cpu_runstate_ctrl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .step_req(step_req),
        .term_seen(term_seen), .last_inflight(last_inflight), .retire_seen(retire_seen),
        .status(status), .fetch_en(fetch_en), .adv_en(adv_en),
        .cycle_cnt(cycle_cnt), .retired_cnt(retired_cnt)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, capture enables, return after rising edge
    task automatic cyc(input logic ld, input logic st, input logic tm,
                       input logic lst, input logic rt);
        @(negedge clk);
        load_pulse = ld; step_req = st; term_seen = tm;
        last_inflight = lst; retire_seen = rt;
        #1;
        seen_adv = adv_en;
        seen_fetch = fetch_en;
        @(posedge clk);
        #1;
        load_pulse = 0; step_req = 0; term_seen = 0; last_inflight = 0; retire_seen = 0;
    endtask

    task automatic expect_regs(input string req, input int s, input int c, input int r);
        chk({req, " status"}, status, s);
        chk({req, " cycle_cnt"}, cycle_cnt, c);
        chk({req, " retired_cnt"}, retired_cnt, r);
    endtask

    task automatic t_reset;
        #1;
        expect_regs("R1", 0, 0, 0);
        chk("R1 adv_en", adv_en, 0);
        chk("R1 fetch_en", fetch_en, 0);
    endtask

    task automatic t_first_step;
        cyc(0, 1, 0, 0, 0);
        chk("R3 adv_en", seen_adv, 1);
        chk("R11 fetch_en", seen_fetch, 1);
        expect_regs("R3 R2", 1, 1, 0);
    endtask

    task automatic t_pause;
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 0, 1);
            chk("R4 pause adv_en", seen_adv, 0);
        end
        expect_regs("R4 pause", 1, 1, 0);
    endtask

    task automatic t_run;
        for (int i = 0; i < 3; i++) begin
            cyc(0, 1, 0, 0, 1);
            chk("R11 fetch_en", seen_fetch, 1);
        end
        expect_regs("R4 R5", 1, 4, 3);
        cyc(0, 1, 0, 0, 0);
        expect_regs("R5 no retire", 1, 5, 3);
    endtask

    task automatic t_terminate;
        cyc(0, 1, 1, 0, 1);
        chk("R6 adv_en", seen_adv, 1);
        chk("R6 fetch_en", seen_fetch, 0);
        expect_regs("R6 R2", 2, 6, 4);
    endtask

    task automatic t_drain;
        cyc(0, 1, 0, 0, 1);
        chk("R7 adv_en", seen_adv, 1);
        chk("R7 fetch_en", seen_fetch, 0);
        expect_regs("R7", 2, 7, 5);
        cyc(0, 0, 0, 1, 1);
        expect_regs("R4 pause in drain", 2, 7, 5);
    endtask

    task automatic t_final;
        cyc(0, 1, 0, 1, 1);
        chk("R8 adv_en", seen_adv, 1);
        chk("R8 fetch_en", seen_fetch, 0);
        expect_regs("R8 R2", 3, 7, 6);
    endtask

    task automatic t_stopped;
        for (int i = 0; i < 2; i++) begin
            cyc(0, 1, 1, 1, 1);
            chk("R9 adv_en", seen_adv, 0);
            chk("R9 fetch_en", seen_fetch, 0);
        end
        expect_regs("R9", 3, 7, 6);
    endtask

    task automatic t_load(input string tag);
        cyc(1, 1, 0, 0, 1);
        chk({"R10 adv_en ", tag}, seen_adv, 0);
        chk({"R10 fetch_en ", tag}, seen_fetch, 0);
        expect_regs({"R10 ", tag}, 0, 0, 0);
    endtask

    task automatic t_load_midrun;
        cyc(0, 1, 0, 0, 1);
        cyc(0, 1, 0, 0, 1);
        expect_regs("R3 rerun", 1, 2, 2);
        t_load("executing");
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 1);
        expect_regs("R6 rerun", 2, 2, 1);
        t_load("draining");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_first_step();
                t_pause();
                t_run();
                t_terminate();
                t_drain();
                t_final();
                t_stopped();
                t_load("stopped");
                t_load_midrun();
            end
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule